// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block sits between one bidirectional pin and the core logic of a programmable device. It is set up once, when reset is released, to act as a plain input, a registered input, a latched input, an output, or a bidirectional pin. The pin itself is described by three signals: the value the pad sees (`pad_in`), the value to drive (`pad_out`) and a drive enable (`pad_oe`). The pad driver outside the block turns these into the three-state pin.

On the receive side the cell passes the pin straight through, captures it in a register, or holds it in a latch. The register and the latch are timed by one of several I/O clock strobes, and the configuration picks which one. The strobes are qualified against the core clock, so everything stays on one clock.

On the send side the pin is driven only when three things hold: the mode drives, the local enable is high, and the chosen global enable is high. Each cell can be a push-pull (totem-pole) driver or an open-drain driver. Open-drain pulls the pin low for a 0 and releases it for a 1, so an external pull-up sets the level. After reset the cell is always a quiet, push-pull plain input until it takes its new configuration.

Top module: `bidir_io_cell`

## Requirements
- R1: While `rst_n` is low, `pad_oe` and `pad_out` are 0 and the cell behaves as a push-pull plain input, so `core_in` equals `pad_in`.
- R2: The configuration inputs are taken on the first rising clock edge after `rst_n` goes high. Later changes to them have no effect until the next reset.
- R3: Mode code 0 (plain input): `core_in` equals `pad_in` in the same cycle. Codes 5 to 7 behave as code 0.
- R4: Mode code 1 (registered input): `core_in` is 0 after reset. At each clock edge where the selected strobe is high, `core_in` takes the value `pad_in` had before that edge. At any other edge `core_in` keeps its value.
- R5: Mode code 2 (latched input): `core_in` is 0 after reset. While the selected strobe is high, `core_in` follows `pad_in`. While the strobe is low, it holds the value taken at the last edge where the strobe was high.
- R6: `cfg_clk_sel` = k selects `ioclk_en[k]`. Strobes that are not selected have no effect on the registered or latched value.
- R7: Mode codes 3 (output) and 4 (bidirectional) with push-pull selected (`cfg_open_drain` = 0): `pad_oe` = `local_oe` AND the global gate, and `pad_out` = `core_out` AND `pad_oe`.
- R8: The global gate is always open when `cfg_goe_sel` = 0. It equals `goe[0]` for `cfg_goe_sel` = 1 and `goe[1]` for `cfg_goe_sel` = 2.
- R9: With `cfg_open_drain` = 1, `pad_out` is always 0. `pad_oe` is 1 only when the enable conditions of R7 hold and `core_out` is 0. A 1 therefore leaves the pin to the external pull-up, and an external low on the pin reads back as 0.
- R10: In mode codes 0, 1 and 2, `pad_oe` stays 0 whatever `local_oe`, `goe` and `core_out` are.
- R11: In mode codes 3 and 4, `core_in` equals `pad_in` in the same cycle, so the level actually on the pin can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low global reset, asynchronous assert |
| cfg_mode | input | 3 | Mode code, taken at reset release |
| cfg_open_drain | input | 1 | 1 selects open-drain driving |
| cfg_goe_sel | input | 2 | Global enable select: 0 none, k selects goe[k-1] |
| cfg_clk_sel | input | 2 | Index of the I/O clock strobe |
| goe | input | 2 | Global output enable lines |
| ioclk_en | input | 3 | I/O clock strobes (two external, one internal) |
| core_out | input | 1 | Data to drive on the pin |
| local_oe | input | 1 | Per-cell output enable |
| core_in | output | 1 | Value delivered to the core |
| pad_in | input | 1 | Level currently on the pin |
| pad_out | output | 1 | Value for the pad driver |
| pad_oe | output | 1 | Pad driver enable |

## Verification
A corrupted configuration register shows up one cycle after reset release. The pin is then driven in an input mode, or `core_in` comes from the wrong source, so the cell keeps showing the wrong behaviour until the next reset. A capture register that loads on the wrong strobe, or fails to hold, shows on `core_in` right after the clock edge in question. The open-drain and global-enable faults act combinationally and appear on `pad_oe`/`pad_out` in the same cycle as the stimulus.

// File: rtl/iocell_pkg.sv
`timescale 1ns/1ps
package iocell_pkg;

    typedef enum logic [2:0] {
        MODE_COMB  = 3'd0,
        MODE_REG   = 3'd1,
        MODE_LATCH = 3'd2,
        MODE_OUT   = 3'd3,
        MODE_BIDIR = 3'd4
    } io_mode_e;

    // Unused codes fall back to the quiet plain-input mode.
    function automatic io_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_REG;
            3'd2:    return MODE_LATCH;
            3'd3:    return MODE_OUT;
            3'd4:    return MODE_BIDIR;
            default: return MODE_COMB;
        endcase
    endfunction

    function automatic logic mode_drives(input io_mode_e m);
        return (m == MODE_OUT) || (m == MODE_BIDIR);
    endfunction

endpackage

// File: rtl/iocell_cfg_hold.sv
`timescale 1ns/1ps
module iocell_cfg_hold
    import iocell_pkg::*;
#(
    parameter int GSEL_W = 2,
    parameter int CSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode_i,
    input  logic              cfg_od_i,
    input  logic [GSEL_W-1:0] cfg_gsel_i,
    input  logic [CSEL_W-1:0] cfg_csel_i,
    output io_mode_e          mode_o,
    output logic              od_o,
    output logic [GSEL_W-1:0] gsel_o,
    output logic [CSEL_W-1:0] csel_o
);

    typedef struct packed {
        logic              armed;
        io_mode_e          mode;
        logic              od;
        logic [GSEL_W-1:0] gsel;
        logic [CSEL_W-1:0] csel;
    } cfg_state_t;

    localparam cfg_state_t CFG_RST = '{
        armed: 1'b0,
        mode:  MODE_COMB,
        od:    1'b0,
        gsel:  '0,
        csel:  '0
    };

    cfg_state_t cfg_d, cfg_q;

    // Load once, on the first edge after reset release, then freeze.
    always_comb begin
        cfg_d = cfg_q;
        if (!cfg_q.armed) begin
            cfg_d.armed = 1'b1;
            cfg_d.mode  = decode_mode(cfg_mode_i);
            cfg_d.od    = cfg_od_i;
            cfg_d.gsel  = cfg_gsel_i;
            cfg_d.csel  = cfg_csel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o = cfg_q.mode;
    assign od_o   = cfg_q.od;
    assign gsel_o = cfg_q.gsel;
    assign csel_o = cfg_q.csel;

    // R2: once armed, the stored configuration never moves until reset.
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.armed |=> $stable({cfg_q.mode, cfg_q.od, cfg_q.gsel, cfg_q.csel}));

endmodule

// File: rtl/iocell_in_path.sv
`timescale 1ns/1ps
module iocell_in_path
    import iocell_pkg::*;
#(
    parameter int NUM_IOCLK = 3,
    parameter int CSEL_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  io_mode_e             mode_i,
    input  logic [CSEL_W-1:0]    csel_i,
    input  logic [NUM_IOCLK-1:0] ioclk_en_i,
    input  logic                 pad_i,
    output logic                 core_in_o
);

    typedef struct packed {
        logic reg_v;
        logic lat_v;
    } cap_state_t;

    cap_state_t cap_d, cap_q;
    logic [NUM_IOCLK-1:0] clk_hit;
    logic sel_en;

    for (genvar g = 0; g < NUM_IOCLK; g++) begin : g_clk_pick
        assign clk_hit[g] = (csel_i == CSEL_W'(g)) && ioclk_en_i[g];
    end
    assign sel_en = |clk_hit;

    always_comb begin
        cap_d = cap_q;
        if (sel_en && (mode_i == MODE_REG))   cap_d.reg_v = pad_i;
        if (sel_en && (mode_i == MODE_LATCH)) cap_d.lat_v = pad_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // Latch is transparent while the selected strobe is high.
    always_comb begin
        case (mode_i)
            MODE_REG:   core_in_o = cap_q.reg_v;
            MODE_LATCH: core_in_o = sel_en ? pad_i : cap_q.lat_v;
            default:    core_in_o = pad_i;
        endcase
    end

    assert_reg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> $stable(cap_q.reg_v));

    assert_reg_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_en && (mode_i == MODE_REG)) |=> (cap_q.reg_v == $past(pad_i)));

    assert_lat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> $stable(cap_q.lat_v));

endmodule

// File: rtl/iocell_out_drv.sv
`timescale 1ns/1ps
module iocell_out_drv
    import iocell_pkg::*;
#(
    parameter int NUM_GOE = 2,
    parameter int GSEL_W  = 2
) (
    input  io_mode_e           mode_i,
    input  logic               od_i,
    input  logic [GSEL_W-1:0]  gsel_i,
    input  logic [NUM_GOE-1:0] goe_i,
    input  logic               local_oe_i,
    input  logic               data_i,
    output logic               pad_out_o,
    output logic               pad_oe_o
);

    logic [NUM_GOE-1:0] goe_hit;
    logic glob_en;
    logic drive;

    for (genvar g = 0; g < NUM_GOE; g++) begin : g_goe_pick
        assign goe_hit[g] = (gsel_i == GSEL_W'(g + 1)) && goe_i[g];
    end

    assign glob_en = (gsel_i == '0) || (|goe_hit);
    assign drive   = mode_drives(mode_i) && local_oe_i && glob_en;

    // Open-drain: enable only to pull low, never drive a high.
    always_comb begin
        pad_oe_o  = drive && (!od_i || !data_i);
        pad_out_o = drive && !od_i && data_i;
    end

endmodule

// File: rtl/bidir_io_cell.sv
`timescale 1ns/1ps
module bidir_io_cell
    import iocell_pkg::*;
#(
    parameter  int NUM_GOE   = 2,
    parameter  int NUM_IOCLK = 3,
    localparam int GSEL_W    = $clog2(NUM_GOE + 1),
    localparam int CSEL_W    = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cfg_mode,
    input  logic                 cfg_open_drain,
    input  logic [GSEL_W-1:0]    cfg_goe_sel,
    input  logic [CSEL_W-1:0]    cfg_clk_sel,
    input  logic [NUM_GOE-1:0]   goe,
    input  logic [NUM_IOCLK-1:0] ioclk_en,
    input  logic                 core_out,
    input  logic                 local_oe,
    output logic                 core_in,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe
);

    io_mode_e          mode_q;
    logic              od_q;
    logic [GSEL_W-1:0] gsel_q;
    logic [CSEL_W-1:0] csel_q;

    iocell_cfg_hold #(.GSEL_W(GSEL_W), .CSEL_W(CSEL_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode_i (cfg_mode),
        .cfg_od_i   (cfg_open_drain),
        .cfg_gsel_i (cfg_goe_sel),
        .cfg_csel_i (cfg_clk_sel),
        .mode_o     (mode_q),
        .od_o       (od_q),
        .gsel_o     (gsel_q),
        .csel_o     (csel_q)
    );

    iocell_in_path #(.NUM_IOCLK(NUM_IOCLK), .CSEL_W(CSEL_W)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_q),
        .csel_i     (csel_q),
        .ioclk_en_i (ioclk_en),
        .pad_i      (pad_in),
        .core_in_o  (core_in)
    );

    iocell_out_drv #(.NUM_GOE(NUM_GOE), .GSEL_W(GSEL_W)) u_out (
        .mode_i     (mode_q),
        .od_i       (od_q),
        .gsel_i     (gsel_q),
        .goe_i      (goe),
        .local_oe_i (local_oe),
        .data_i     (core_out),
        .pad_out_o  (pad_out),
        .pad_oe_o   (pad_oe)
    );

    assert_input_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q inside {MODE_COMB, MODE_REG, MODE_LATCH}) |-> !pad_oe);

    assert_oe_needs_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> local_oe);

    assert_od_low_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q && pad_oe) |-> (!pad_out && !core_out));

    assert_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q inside {MODE_OUT, MODE_BIDIR}) |-> (core_in == pad_in));

endmodule

// File: tb/bidir_io_cell_test.sv
`timescale 1ns/1ps
module bidir_io_cell_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic       cfg_od = 1'b0;
    logic [1:0] cfg_gsel = 2'd0;
    logic [1:0] cfg_csel = 2'd0;
    logic [1:0] goe = 2'b00;
    logic [2:0] strb = 3'b000;
    logic       core_out = 1'b0;
    logic       local_oe = 1'b0;
    logic       ext_en = 1'b0;
    logic       ext_val = 1'b0;
    logic       core_in, pad_in, pad_out, pad_oe;

    // Pin model: pull-up, wired-AND with an optional external low driver.
    logic own_level;
    assign own_level = pad_oe ? pad_out : 1'b1;
    assign pad_in    = ext_en ? (ext_val & own_level) : own_level;

    always #5 clk = ~clk;

    bidir_io_cell uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_mode       (cfg_mode),
        .cfg_open_drain (cfg_od),
        .cfg_goe_sel    (cfg_gsel),
        .cfg_clk_sel    (cfg_csel),
        .goe            (goe),
        .ioclk_en       (strb),
        .core_out       (core_out),
        .local_oe       (local_oe),
        .core_in        (core_in),
        .pad_in         (pad_in),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe)
    );

    typedef struct {
        string tag;
        logic  ci;
        logic  oe;
        logic  po;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic step(input logic co, input logic loe, input logic [1:0] g,
                        input logic [2:0] s, input logic xe, input logic xv,
                        input logic eci, input logic eoe, input logic epo,
                        input string tag);
        exp_t e;
        @(negedge clk);
        core_out = co; local_oe = loe; goe = g; strb = s;
        ext_en = xe; ext_val = xv;
        @(posedge clk);
        #1;
        e.tag = tag; e.ci = eci; e.oe = eoe; e.po = epo;
        q.push_back(e);
    endtask

    task automatic begin_reset(input logic [2:0] m, input logic od,
                               input logic [1:0] gs, input logic [1:0] cs);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = m; cfg_od = od; cfg_gsel = gs; cfg_csel = cs;
        core_out = 1'b0; local_oe = 1'b0; goe = 2'b00; strb = 3'b000;
        ext_en = 1'b0; ext_val = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
    endtask

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if ({core_in, pad_oe, pad_out} !== {e.ci, e.oe, e.po}) begin
                    n_bad++;
                    $display("FAIL %s: got core_in=%b pad_oe=%b pad_out=%b, expected core_in=%b pad_oe=%b pad_out=%b",
                             e.tag, core_in, pad_oe, pad_out, e.ci, e.oe, e.po);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Output mode, push-pull, no global gate
        begin_reset(3'd3, 1'b0, 2'd0, 2'd0);
        step(1, 1, 2'b00, 3'b000, 0, 0, 1, 0, 0, "R1 quiet during reset");
        end_reset();
        step(1, 1, 2'b00, 3'b000, 0, 0, 1, 1, 1, "R7 push-pull drives high");
        step(0, 1, 2'b00, 3'b000, 0, 0, 0, 1, 0, "R7 R11 drives low and reads back");
        step(1, 0, 2'b00, 3'b000, 0, 0, 1, 0, 0, "R7 local enable off");
        cfg_mode = 3'd0;
        step(1, 1, 2'b00, 3'b000, 0, 0, 1, 1, 1, "R2 config change ignored");

        // Bidirectional, gated by goe[0]
        begin_reset(3'd4, 1'b0, 2'd1, 2'd0);
        end_reset();
        step(1, 1, 2'b00, 3'b000, 0, 0, 1, 0, 0, "R8 goe0 low blocks");
        step(1, 1, 2'b01, 3'b000, 0, 0, 1, 1, 1, "R8 goe0 high enables");
        step(1, 1, 2'b10, 3'b000, 0, 0, 1, 0, 0, "R8 unselected goe1 ignored");
        step(0, 0, 2'b01, 3'b000, 1, 0, 0, 0, 0, "R11 bidir receives external low");

        // Bidirectional, gated by goe[1]
        begin_reset(3'd4, 1'b0, 2'd2, 2'd0);
        end_reset();
        step(1, 1, 2'b10, 3'b000, 0, 0, 1, 1, 1, "R8 goe1 high enables");
        step(1, 1, 2'b01, 3'b000, 0, 0, 1, 0, 0, "R8 goe1 low blocks");

        // Output mode, open-drain
        begin_reset(3'd3, 1'b1, 2'd0, 2'd0);
        end_reset();
        step(0, 1, 2'b00, 3'b000, 0, 0, 0, 1, 0, "R9 open-drain pulls low");
        step(1, 1, 2'b00, 3'b000, 0, 0, 1, 0, 0, "R9 open-drain releases for 1");
        step(1, 1, 2'b00, 3'b000, 1, 0, 0, 0, 0, "R9 wired low reads back");

        // Plain input
        begin_reset(3'd0, 1'b0, 2'd0, 2'd0);
        end_reset();
        step(1, 1, 2'b11, 3'b000, 1, 0, 0, 0, 0, "R3 R10 plain input low, no drive");
        step(1, 1, 2'b11, 3'b000, 1, 1, 1, 0, 0, "R3 plain input high");

        // Registered input on strobe 1
        begin_reset(3'd1, 1'b0, 2'd0, 2'd1);
        end_reset();
        step(1, 1, 2'b00, 3'b000, 1, 1, 0, 0, 0, "R4 R10 register cleared, no drive");
        step(0, 0, 2'b00, 3'b010, 1, 1, 1, 0, 0, "R4 register captures high");
        step(0, 0, 2'b00, 3'b000, 1, 0, 1, 0, 0, "R4 register holds");
        step(0, 0, 2'b00, 3'b101, 1, 0, 1, 0, 0, "R6 unselected strobes ignored");
        step(0, 0, 2'b00, 3'b010, 1, 0, 0, 0, 0, "R4 register captures low");

        // Latched input on strobe 2
        begin_reset(3'd2, 1'b0, 2'd0, 2'd2);
        end_reset();
        step(0, 0, 2'b00, 3'b000, 1, 1, 0, 0, 0, "R5 latch cleared");
        step(0, 0, 2'b00, 3'b100, 1, 1, 1, 0, 0, "R5 latch transparent high");
        step(0, 0, 2'b00, 3'b100, 1, 0, 0, 0, 0, "R5 latch follows low");
        step(0, 0, 2'b00, 3'b000, 1, 1, 0, 0, 0, "R5 latch holds");
        step(0, 0, 2'b00, 3'b011, 1, 1, 0, 0, 0, "R6 latch ignores other strobes");
        step(0, 0, 2'b00, 3'b100, 1, 1, 1, 0, 0, "R5 latch reopens");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule